// File: doc/BRIEF.md
# Chained Rule Control Stage

This block is one link in a chain of identical filter stages. Every packet reaches it as three things that travel together. The first is a byte stream holding the packet's rule list. The second is a wide parameter bus holding the already-extracted header fields. The third is the frame itself, a stream of beats. Each stage carries a fixed identifier. It looks only at the rule at the head of the list. When that rule's type byte equals the identifier, the stage consumes the rule, compares it with the selected header field and carries out the rule's action. A discard action drops the whole packet. Otherwise the packet moves on without the consumed rule, so the following stage finds the next rule at the head.

Each rule is a type byte, then a length byte, then that many value bytes. The first value byte holds the action in bit 7 and the field selector in bits 3:0. The remaining value bytes are the compare value, most significant byte first. A rule list must end with a terminator rule of type 0 and length 0, so that removing a rule never leaves an empty list. The stage identifier must be non-zero. NUM_FIELDS must not exceed 16.

For each packet the rule stream goes first and the frame second. A stage adds no latency on its pass-through paths: output valid and input ready are wired through in the same cycle.

Top module: `rule_ctrl_stage`

## Requirements
- R1: While reset is applied and after it, neither output stream is valid, and `fr_in_ready` is low until a rule list has been fully accepted.
- R2: When the head rule's type differs from STAGE_ID, every rule byte is forwarded unchanged with its last flag, and so is every frame beat.
- R3: Only the head rule is examined. A rule carrying STAGE_ID at any later position passes through untouched.
- R4: When the head type equals STAGE_ID, the type, length and value bytes of that rule never appear on the output. The output rule list begins with the byte that follows the rule.
- R5: A rule is complete only when its length byte equals 1 + FIELD_W/8. In the first value byte, bit 7 is the action (1 = discard, 0 = forward) and bits 3:0 are the field selector. The following FIELD_W/8 bytes are the compare value, MSB first. A rule of any other length, including length 0, counts as a mismatch.
- R6: A complete rule whose value equals the selected field and whose action bit is 1 discards the packet. The remaining rule bytes and all frame beats are accepted, and no output valid is asserted for them.
- R7: A complete matching rule whose action bit is 0 lets the packet through, minus the consumed rule.
- R8: A mismatching rule lets the packet through, minus the consumed rule, whatever its action bit.
- R9: A selector of NUM_FIELDS or more never matches.
- R10: No frame beat is accepted before the last rule byte has been accepted. Once the frame's last beat is accepted, the next rule list is accepted.
- R11: On every output beat of a packet, `par_out` equals the value of `par_in` at that packet's first rule byte. Field i occupies bits [i*FIELD_W +: FIELD_W].
- R12: Under output back-pressure, no byte or beat is lost, duplicated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_in | input | NUM_FIELDS*FIELD_W | Parameter set of the current packet, held stable for the whole packet |
| par_out | output | NUM_FIELDS*FIELD_W | Parameter set passed to the next stage |
| rs_in_valid | input | 1 | Rule byte valid |
| rs_in_ready | output | 1 | Rule byte accepted |
| rs_in_data | input | 8 | Rule byte |
| rs_in_last | input | 1 | Final byte of the rule list |
| rs_out_valid | output | 1 | Outgoing rule byte valid |
| rs_out_ready | input | 1 | Next stage accepts a rule byte |
| rs_out_data | output | 8 | Outgoing rule byte |
| rs_out_last | output | 1 | Final outgoing rule byte |
| fr_in_valid | input | 1 | Frame beat valid |
| fr_in_ready | output | 1 | Frame beat accepted |
| fr_in_data | input | FRAME_W | Frame beat |
| fr_in_last | input | 1 | Final frame beat |
| fr_out_valid | output | 1 | Outgoing frame beat valid |
| fr_out_ready | input | 1 | Next stage accepts a frame beat |
| fr_out_data | output | FRAME_W | Outgoing frame beat |
| fr_out_last | output | 1 | Final outgoing frame beat |

## Verification
The bench builds the stage with STAGE_ID 3, four 16-bit fields and 16-bit frame beats. With these values a complete rule is only five bytes long, and every selector from 4 to 15 is out of range. Hand-written packets therefore reach every path: mismatch on value, mismatch on selector, wrong length, both actions, and a second rule with the same identifier. The frame driver starts while the rule list is still being sent, which exercises the gating. Random ready on both outputs covers back-pressure on the wired-through paths.

// File: rtl/crs_pkg.sv
package crs_pkg;

    // Packet phases of one stage; the encoding of ST_HEAD must be zero (reset value)
    typedef enum logic [2:0] {
        ST_HEAD    = 3'd0,
        ST_LEN     = 3'd1,
        ST_VAL     = 3'd2,
        ST_RS_FWD  = 3'd3,
        ST_RS_DROP = 3'd4,
        ST_FR_FWD  = 3'd5,
        ST_FR_DROP = 3'd6
    } crs_state_e;

    localparam int unsigned SEL_W = 4;

endpackage

// File: rtl/crs_field_sel.sv
module crs_field_sel #(
    parameter int unsigned NUM_FIELDS = 10,
    parameter int unsigned FIELD_W    = 48,
    localparam int unsigned PAR_W     = NUM_FIELDS * FIELD_W
) (
    input  logic [PAR_W-1:0]   par_i,
    input  logic [3:0]         sel_i,
    output logic [FIELD_W-1:0] field_o,
    output logic               sel_ok_o
);

    logic [FIELD_W-1:0] fields [NUM_FIELDS];

    generate
        for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_split
            assign fields[g] = par_i[g*FIELD_W +: FIELD_W];
        end
    endgenerate

    // R9: selectors at or above NUM_FIELDS leave sel_ok_o low
    always_comb begin
        field_o  = '0;
        sel_ok_o = 1'b0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (sel_i == 4'(i)) begin
                field_o  = fields[i];
                sel_ok_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/crs_rule_eval.sv
module crs_rule_eval #(
    parameter int unsigned FIELD_W = 48
) (
    input  logic [FIELD_W-1:0] field_i,
    input  logic               sel_ok_i,
    input  logic               complete_i,
    input  logic [FIELD_W-1:0] cmp_i,
    input  logic               act_i,
    output logic               match_o,
    output logic               discard_o
);

    // R5, R9: only a complete rule with an in-range selector can match
    always_comb begin
        match_o   = complete_i && sel_ok_i && (field_i == cmp_i);
        discard_o = match_o && act_i;     // R6 discard, R7/R8 forward otherwise
    end

endmodule

// File: rtl/rule_ctrl_stage.sv
module rule_ctrl_stage
    import crs_pkg::*;
#(
    parameter logic [7:0]  STAGE_ID   = 8'd1,
    parameter int unsigned NUM_FIELDS = 10,
    parameter int unsigned FIELD_W    = 48,
    parameter int unsigned FRAME_W    = 32,
    localparam int unsigned PAR_W       = NUM_FIELDS * FIELD_W,
    localparam int unsigned FIELD_BYTES = (FIELD_W + 7) / 8,
    localparam logic [7:0]  RULE_LEN    = 8'(FIELD_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PAR_W-1:0]   par_in,
    output logic [PAR_W-1:0]   par_out,
    input  logic               rs_in_valid,
    output logic               rs_in_ready,
    input  logic [7:0]         rs_in_data,
    input  logic               rs_in_last,
    output logic               rs_out_valid,
    input  logic               rs_out_ready,
    output logic [7:0]         rs_out_data,
    output logic               rs_out_last,
    input  logic               fr_in_valid,
    output logic               fr_in_ready,
    input  logic [FRAME_W-1:0] fr_in_data,
    input  logic               fr_in_last,
    output logic               fr_out_valid,
    input  logic               fr_out_ready,
    output logic [FRAME_W-1:0] fr_out_data,
    output logic               fr_out_last
);

    typedef struct packed {
        crs_state_e         st;
        logic [7:0]         left;
        logic               len_ok;
        logic               first;
        logic [SEL_W-1:0]   sel;
        logic               act;
        logic [FIELD_W-1:0] cmp;
        logic [PAR_W-1:0]   par;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [FIELD_W-1:0] cmp_next;
    logic [FIELD_W-1:0] field_sel;
    logic               sel_ok;
    logic               rule_match;
    logic               rule_drop;

    assign cmp_next = FIELD_W'({regs_q.cmp, rs_in_data});

    crs_field_sel #(
        .NUM_FIELDS (NUM_FIELDS),
        .FIELD_W    (FIELD_W)
    ) u_sel (
        .par_i    (regs_q.par),
        .sel_i    (regs_q.sel),
        .field_o  (field_sel),
        .sel_ok_o (sel_ok)
    );

    crs_rule_eval #(
        .FIELD_W (FIELD_W)
    ) u_eval (
        .field_i    (field_sel),
        .sel_ok_i   (sel_ok),
        .complete_i (regs_q.len_ok),
        .cmp_i      (cmp_next),
        .act_i      (regs_q.act),
        .match_o    (rule_match),
        .discard_o  (rule_drop)
    );

    // R11: parameters pass straight through until captured at the first rule byte
    assign par_out = (regs_q.st == ST_HEAD) ? par_in : regs_q.par;

    always_comb begin
        regs_d       = regs_q;
        rs_in_ready  = 1'b0;
        rs_out_valid = 1'b0;
        fr_in_ready  = 1'b0;
        fr_out_valid = 1'b0;
        rs_out_data  = rs_in_data;
        rs_out_last  = rs_in_last;
        fr_out_data  = fr_in_data;
        fr_out_last  = fr_in_last;

        unique case (regs_q.st)
            ST_HEAD: begin
                if (rs_in_data != STAGE_ID) begin
                    // R2, R3: foreign head rule, pass the byte on
                    rs_out_valid = rs_in_valid;
                    rs_in_ready  = rs_out_ready;
                    if (rs_in_valid && rs_out_ready) begin
                        regs_d.par = par_in;
                        regs_d.st  = rs_in_last ? ST_FR_FWD : ST_RS_FWD;
                    end
                end else begin
                    // R4: own head rule, swallow the type byte
                    rs_in_ready = 1'b1;
                    if (rs_in_valid) begin
                        regs_d.par = par_in;
                        regs_d.st  = rs_in_last ? ST_FR_FWD : ST_LEN;
                    end
                end
            end

            ST_LEN: begin
                rs_in_ready = 1'b1;
                if (rs_in_valid) begin
                    regs_d.left   = rs_in_data;
                    regs_d.len_ok = (rs_in_data == RULE_LEN);   // R5
                    regs_d.first  = 1'b1;
                    regs_d.cmp    = '0;
                    if (rs_in_last)
                        regs_d.st = ST_FR_FWD;
                    else if (rs_in_data == 8'd0)
                        regs_d.st = ST_RS_FWD;                  // R5: empty value, mismatch
                    else
                        regs_d.st = ST_VAL;
                end
            end

            ST_VAL: begin
                rs_in_ready = 1'b1;
                if (rs_in_valid) begin
                    regs_d.left = regs_q.left - 8'd1;
                    if (regs_q.first) begin
                        regs_d.sel   = rs_in_data[SEL_W-1:0];
                        regs_d.act   = rs_in_data[7];
                        regs_d.first = 1'b0;
                    end else begin
                        regs_d.cmp = cmp_next;
                    end
                    if (regs_q.left == 8'd1) begin
                        // R6, R7, R8: act on the verdict
                        if (rule_drop)
                            regs_d.st = rs_in_last ? ST_FR_DROP : ST_RS_DROP;
                        else
                            regs_d.st = rs_in_last ? ST_FR_FWD : ST_RS_FWD;
                    end else if (rs_in_last) begin
                        regs_d.st = ST_FR_FWD;                  // truncated rule
                    end
                end
            end

            ST_RS_FWD: begin
                rs_out_valid = rs_in_valid;
                rs_in_ready  = rs_out_ready;
                if (rs_in_valid && rs_out_ready && rs_in_last)
                    regs_d.st = ST_FR_FWD;
            end

            ST_RS_DROP: begin
                rs_in_ready = 1'b1;
                if (rs_in_valid && rs_in_last)
                    regs_d.st = ST_FR_DROP;
            end

            ST_FR_FWD: begin
                fr_out_valid = fr_in_valid;
                fr_in_ready  = fr_out_ready;
                if (fr_in_valid && fr_out_ready && fr_in_last)
                    regs_d.st = ST_HEAD;                        // R10
            end

            ST_FR_DROP: begin
                fr_in_ready = 1'b1;
                if (fr_in_valid && fr_in_last)
                    regs_d.st = ST_HEAD;
            end

            default: regs_d.st = ST_HEAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            regs_q <= '0;
        else
            regs_q <= regs_d;
    end

    // ---------------- assertions ----------------
    logic in_rule_phase;
    assign in_rule_phase = (regs_q.st == ST_HEAD) || (regs_q.st == ST_LEN) ||
                           (regs_q.st == ST_VAL)  || (regs_q.st == ST_RS_FWD) ||
                           (regs_q.st == ST_RS_DROP);

    a_r10_frame_gated: assert property (@(posedge clk) disable iff (!rst_n)
        in_rule_phase |-> (!fr_in_ready && !fr_out_valid));

    a_r6_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ST_RS_DROP || regs_q.st == ST_FR_DROP) |-> (!rs_out_valid && !fr_out_valid));

    a_r4_rule_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ST_LEN || regs_q.st == ST_VAL) |-> !rs_out_valid);

    a_r4_head_stripped: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ST_HEAD && rs_out_valid) |-> (rs_out_data != STAGE_ID));

    a_r11_param_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st != ST_HEAD) |=> ((regs_q.st == ST_HEAD) || $stable(par_out)));

    a_r5_value_count: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ST_VAL) |-> (regs_q.left != 8'd0));

endmodule

// File: tb/rule_ctrl_stage_bench.sv
module rule_ctrl_stage_bench;

    localparam logic [7:0]  SID = 8'd3;
    localparam int unsigned NF  = 4;
    localparam int unsigned FW  = 16;
    localparam int unsigned FRW = 16;
    localparam int unsigned PW  = NF * FW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [PW-1:0]  par_in = '0;
    logic [PW-1:0]  par_out;
    logic           rs_in_valid = 1'b0, rs_in_last = 1'b0, rs_in_ready;
    logic [7:0]     rs_in_data = '0;
    logic           rs_out_valid, rs_out_last, rs_out_ready = 1'b1;
    logic [7:0]     rs_out_data;
    logic           fr_in_valid = 1'b0, fr_in_last = 1'b0, fr_in_ready;
    logic [FRW-1:0] fr_in_data = '0;
    logic           fr_out_valid, fr_out_last, fr_out_ready = 1'b1;
    logic [FRW-1:0] fr_out_data;

    rule_ctrl_stage #(
        .STAGE_ID   (SID),
        .NUM_FIELDS (NF),
        .FIELD_W    (FW),
        .FRAME_W    (FRW)
    ) u_rule_ctrl_stage (
        .clk, .rst_n, .par_in, .par_out,
        .rs_in_valid, .rs_in_ready, .rs_in_data, .rs_in_last,
        .rs_out_valid, .rs_out_ready, .rs_out_data, .rs_out_last,
        .fr_in_valid, .fr_in_ready, .fr_in_data, .fr_in_last,
        .fr_out_valid, .fr_out_ready, .fr_out_data, .fr_out_last
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    bit rs_done = 1'b1;
    bit bp_en  = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    string cur_tag = "R1";

    // expected output model
    logic [7:0]     ers_d[$];
    bit             ers_l[$];
    logic [PW-1:0]  ers_p[$];
    string          ers_t[$];
    logic [FRW-1:0] efr_d[$];
    bit             efr_l[$];
    logic [PW-1:0]  efr_p[$];
    string          efr_t[$];

    logic [7:0] pk[$];

    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rs_out_ready <= bp_en ? lfsr[0] : 1'b1;
        fr_out_ready <= bp_en ? lfsr[3] : 1'b1;
    end

    // monitor, sampled mid low phase
    always @(negedge clk) begin
        #5;
        if (rst_n) begin
            if (rs_out_valid && rs_out_ready) begin
                checks++;
                if (ers_d.size() == 0) begin
                    errors++;
                    $display("FAIL %s unexpected rule byte %h, expected none", cur_tag, rs_out_data);
                end else begin
                    if (rs_out_data !== ers_d[0] || rs_out_last !== ers_l[0]) begin
                        errors++;
                        $display("FAIL %s rule byte %h last %0b, expected %h last %0b",
                                 ers_t[0], rs_out_data, rs_out_last, ers_d[0], ers_l[0]);
                    end
                    if (par_out !== ers_p[0]) begin
                        errors++;
                        $display("FAIL R11 par_out %h, expected %h", par_out, ers_p[0]);
                    end
                    void'(ers_d.pop_front()); void'(ers_l.pop_front());
                    void'(ers_p.pop_front()); void'(ers_t.pop_front());
                end
            end
            if (fr_out_valid && fr_out_ready) begin
                checks++;
                if (efr_d.size() == 0) begin
                    errors++;
                    $display("FAIL %s unexpected frame beat %h, expected none", cur_tag, fr_out_data);
                end else begin
                    if (fr_out_data !== efr_d[0] || fr_out_last !== efr_l[0]) begin
                        errors++;
                        $display("FAIL %s frame beat %h last %0b, expected %h last %0b",
                                 efr_t[0], fr_out_data, fr_out_last, efr_d[0], efr_l[0]);
                    end
                    if (par_out !== efr_p[0]) begin
                        errors++;
                        $display("FAIL R11 par_out %h, expected %h", par_out, efr_p[0]);
                    end
                    void'(efr_d.pop_front()); void'(efr_l.pop_front());
                    void'(efr_p.pop_front()); void'(efr_t.pop_front());
                end
            end
            // R10: no frame beat taken while the rule list is still open
            if (fr_in_valid && !rs_done) begin
                checks++;
                if (fr_in_ready) begin
                    errors++;
                    $display("FAIL R10 fr_in_ready 1 before rule list end, expected 0");
                end
            end
        end
    end

    task automatic model(input logic [PW-1:0] par, input int nfr, input logic [FRW-1:0] base,
                         input string tag);
        int start = 0;
        bit drop = 1'b0;
        if (pk[0] == SID) begin
            logic [7:0] len = pk[1];
            logic [7:0] v0  = pk[2];
            logic [15:0] cmp = {pk[3], pk[4]};
            bit match = (len == 8'd3) && (v0[3:0] < NF) &&
                        (par[v0[3:0]*FW +: FW] == cmp);
            drop  = match && v0[7];
            start = 2 + int'(len);
        end
        if (!drop) begin
            for (int i = start; i < pk.size(); i++) begin
                ers_d.push_back(pk[i]); ers_l.push_back(i == pk.size() - 1);
                ers_p.push_back(par);   ers_t.push_back(tag);
            end
            for (int i = 0; i < nfr; i++) begin
                efr_d.push_back(base + FRW'(i)); efr_l.push_back(i == nfr - 1);
                efr_p.push_back(par);            efr_t.push_back(tag);
            end
        end
    endtask

    task automatic drive_rs();
        bit ok;
        for (int i = 0; i < pk.size(); i++) begin
            if (i == 1 && bp_en) begin
                rs_in_valid = 1'b0;
                @(negedge clk);
            end
            rs_in_valid = 1'b1;
            rs_in_data  = pk[i];
            rs_in_last  = (i == pk.size() - 1);
            do begin
                #5;
                ok = rs_in_ready;
                @(negedge clk);
            end while (!ok);
        end
        rs_in_valid = 1'b0;
        rs_done = 1'b1;
    endtask

    task automatic drive_fr(input int nfr, input logic [FRW-1:0] base);
        bit ok;
        for (int i = 0; i < nfr; i++) begin
            fr_in_valid = 1'b1;
            fr_in_data  = base + FRW'(i);
            fr_in_last  = (i == nfr - 1);
            do begin
                #5;
                ok = fr_in_ready;
                @(negedge clk);
            end while (!ok);
        end
        fr_in_valid = 1'b0;
    endtask

    task automatic send(input string tag, input logic [PW-1:0] par, input int nfr,
                        input logic [FRW-1:0] base);
        cur_tag = tag;
        par_in  = par;
        rs_done = 1'b0;
        model(par, nfr, base, tag);
        fork
            drive_rs();
            drive_fr(nfr, base);
        join
        for (int w = 0; w < 200 && (ers_d.size() != 0 || efr_d.size() != 0); w++)
            @(negedge clk);
        checks++;
        if (ers_d.size() != 0 || efr_d.size() != 0) begin
            errors++;
            $display("FAIL %s pending outputs rule %0d frame %0d, expected 0 0",
                     tag, ers_d.size(), efr_d.size());
            ers_d.delete(); ers_l.delete(); ers_p.delete(); ers_t.delete();
            efr_d.delete(); efr_l.delete(); efr_p.delete(); efr_t.delete();
        end
    endtask

    localparam logic [PW-1:0] PA = {16'hDDDD, 16'hCCCC, 16'hBEEF, 16'h1234};
    localparam logic [PW-1:0] PB = {16'h0F0F, 16'h5555, 16'hA0A0, 16'h7777};

    initial begin
        @(negedge clk);
        #5;
        // R1: reset state
        checks++; if (rs_out_valid !== 1'b0) begin errors++; $display("FAIL R1 rs_out_valid %b, expected 0", rs_out_valid); end
        checks++; if (fr_out_valid !== 1'b0) begin errors++; $display("FAIL R1 fr_out_valid %b, expected 0", fr_out_valid); end
        @(negedge clk);
        rst_n = 1'b1;
        fr_in_valid = 1'b1;
        fr_in_data  = 16'h9999;
        #5;
        checks++; if (fr_in_ready !== 1'b0) begin errors++; $display("FAIL R1 fr_in_ready %b, expected 0", fr_in_ready); end
        checks++; if (fr_out_valid !== 1'b0) begin errors++; $display("FAIL R1 fr_out_valid %b, expected 0", fr_out_valid); end
        @(negedge clk);
        fr_in_valid = 1'b0;

        pk = '{8'h05, 8'h03, 8'h01, 8'hBE, 8'hEF, 8'h00, 8'h00};
        send("R2", PA, 3, 16'h1000);
        pk = '{8'h07, 8'h01, 8'h55, 8'h03, 8'h03, 8'h82, 8'hCC, 8'hCC, 8'h00, 8'h00};
        send("R3", PA, 2, 16'h2000);
        pk = '{8'h03, 8'h03, 8'h01, 8'hBE, 8'hEF, 8'h00, 8'h00};
        send("R4/R7", PA, 4, 16'h3000);
        pk = '{8'h03, 8'h03, 8'h82, 8'hCC, 8'hCC, 8'h09, 8'h00, 8'h00, 8'h00};
        send("R6", PA, 3, 16'h4000);
        pk = '{8'h03, 8'h03, 8'h82, 8'hCC, 8'hCD, 8'h09, 8'h00, 8'h00, 8'h00};
        send("R8", PA, 2, 16'h5000);
        pk = '{8'h03, 8'h03, 8'h89, 8'h00, 8'h00, 8'h00, 8'h00};
        send("R9", PA, 2, 16'h6000);
        pk = '{8'h03, 8'h03, 8'h00, 8'h12, 8'h34, 8'h03, 8'h03, 8'h83, 8'hDD, 8'hDD, 8'h00, 8'h00};
        send("R3/R4", PA, 2, 16'h7000);
        pk = '{8'h03, 8'h00, 8'h00, 8'h00};
        send("R5", PA, 1, 16'h8000);
        pk = '{8'h03, 8'h02, 8'h81, 8'hBE, 8'h00, 8'h00};
        send("R5", PA, 1, 16'h8100);
        pk = '{8'h03, 8'h03, 8'h83, 8'h0F, 8'h0F, 8'h00, 8'h00};
        send("R6", PB, 5, 16'h9000);
        pk = '{8'h03, 8'h03, 8'h82, 8'h55, 8'h55, 8'h00, 8'h00};
        send("R6", PB, 1, 16'h9100);
        pk = '{8'h01, 8'h00, 8'h00, 8'h00};
        send("R10", PB, 2, 16'h9200);

        bp_en = 1'b1;
        for (int k = 0; k < 6; k++) begin
            pk = '{8'h06, 8'h03, 8'h00, 8'h77, 8'h77, 8'h00, 8'h00};
            send("R12", PB, 6, 16'hA000 + 16'(k * 16));
            pk = '{8'h03, 8'h03, 8'h01, 8'hA0, 8'hA0, 8'h03, 8'h00, 8'h00, 8'h00};
            send("R12", PB, 5, 16'hB000 + 16'(k * 16));
            pk = '{8'h03, 8'h03, 8'h80, 8'h77, 8'h77, 8'h00, 8'h00};
            send("R12", PB, 3, 16'hC000 + 16'(k * 16));
        end
        bp_en = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule